// File: doc/BRIEF.md
# System Calibration Correction Pipeline

This block applies system-level calibration to a stream of signed 24-bit conversion samples that have already been self-calibrated. Each sample first has a signed offset coefficient removed, at half-LSB resolution. The result is then multiplied by an unsigned fractional gain coefficient that covers roughly 0.75 to 2. Last, a polarity scale is applied: 1x in bipolar mode or 2x in unipolar mode. The result is rounded to the nearest LSB and clipped to the 24-bit output range, and an overflow flag is raised on clipping.

The offset stage and the gain stage each have their own bypass control. The order of the stages is fixed and does not change with the bypass settings. The pipeline has three register stages and a constant latency in every mode. The coefficients, the bypass controls and the polarity mode are sampled together with each valid sample and travel down the pipeline with it. A change on those inputs therefore affects only the samples accepted after the change.

Top module: `sysCalPipe`

## Requirements
- R1: While reset is asserted and after it is released, with no sample accepted yet, `outValid`, `outData` and `outOvf` are all 0.
- R2: A sample is accepted on a rising edge where `inValid` is 1. Its result appears with `outValid` = 1 after the third rising edge, counting the accepting edge as the first. `outValid` is 1 for exactly one cycle per accepted sample.
- R3: When `offBypass` = 0, `offCoef` is subtracted before gain. `offCoef` is read as signed two's complement with its LSB worth half an output LSB, so a value of 2 removes one output LSB.
- R4: When `offBypass` = 1, `offCoef` has no effect on the result.
- R5: When `gainBypass` = 0, the offset-corrected value is multiplied by `gainCoef`. `gainCoef` is read as unsigned with 1 integer bit and 23 fraction bits, so 0x800000 is unity, 0xC00000 is 1.5 and 0x600000 is 0.75.
- R6: When `gainBypass` = 1, `gainCoef` has no effect and the gain is exactly 1.
- R7: The final value is rounded to the nearest integer LSB, and exact halves round toward positive infinity (-100.5 gives -100, 1.5 gives 2).
- R8: When `unipolar` = 0, the result is clipped to -0x800000..0x7FFFFF. `outOvf` = 1 exactly when clipping happened.
- R9: When `unipolar` = 1, the corrected value is doubled after gain and before rounding. The result is clipped to 0..0xFFFFFF (unsigned), and `outOvf` = 1 exactly when clipping happened.
- R10: Coefficients, bypass controls and mode are captured with each accepted sample. Changing them while a sample is in flight does not change that sample's result. Back-to-back samples with different settings are each corrected with their own settings.
- R11: When `outValid` = 0, `outData` and `outOvf` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inData | input | 24 | Self-calibrated sample, signed |
| offCoef | input | 24 | System offset coefficient, signed, LSB = 0.5 output LSB |
| gainCoef | input | 24 | System gain coefficient, unsigned 1.23 |
| offBypass | input | 1 | 1 skips offset subtraction |
| gainBypass | input | 1 | 1 skips gain multiplication |
| unipolar | input | 1 | 1 selects 2x scale and unsigned output range |
| outValid | output | 1 | Output sample valid |
| outData | output | 24 | Corrected sample |
| outOvf | output | 1 | Result was clipped |

## Verification
The bench targets the half-LSB offset. An odd offset code lands exactly on a tie, so a design that drops the extra fraction bit, or that rounds ties toward zero or away from zero, returns a result one LSB off. It pushes products past both bipolar rails and both unipolar rails. A design that wraps instead of clipping, or that doubles before gain or forgets to double at all, shows the wrong value or a missing overflow flag. It changes every coefficient and control one cycle after each sample is accepted, and it streams back-to-back samples with mixed settings. A design that reads those inputs late rather than carrying them with the sample corrects a sample with its neighbour's settings.

// File: rtl/sysCalPkg.sv
package sysCalPkg;
  // strobes from control to datapath, one group per pipeline stage
  typedef struct packed {
    logic ld1;      // stage 1 load (accepted sample)
    logic ld2;      // stage 2 load
    logic ld3;      // stage 3 / output load
    logic subOff;   // stage 1: subtract offset
    logic mulGain;  // stage 2: apply gain
    logic dblScale; // stage 3: unipolar 2x and unsigned clip
    logic outUni;   // mode of the sample now at the output
  } stageStb_t;
endpackage

// File: rtl/sysCalCtrl.sv
module sysCalCtrl
  import sysCalPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      offBypass,
  input  logic      gainBypass,
  input  logic      unipolar,
  output stageStb_t stb,
  output logic      outValid
);
  logic v1, v2, v3;
  logic gainEn1, uni1, uni2, uni3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      gainEn1 <= 1'b0;
      uni1 <= 1'b0;
      uni2 <= 1'b0;
      uni3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (inValid) begin
        gainEn1 <= !gainBypass;
        uni1 <= unipolar;
      end
      if (v1) uni2 <= uni1;
      if (v2) uni3 <= uni2;
    end
  end

  always_comb begin
    stb.ld1      = inValid;
    stb.ld2      = v1;
    stb.ld3      = v2;
    stb.subOff   = !offBypass;
    stb.mulGain  = gainEn1;
    stb.dblScale = uni2;
    stb.outUni   = uni3;
  end

  assign outValid = v3;

  // R2: output valid is the input valid three edges later
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN, 3)) |-> (outValid == $past(inValid, 3)));
endmodule

// File: rtl/sysCalData.sv
module sysCalData
  import sysCalPkg::*;
#(
  parameter int DataW    = 24,
  parameter int GainW    = 24,
  parameter int GainFrac = GainW - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStb_t        stb,
  input  logic [DataW-1:0] inData,
  input  logic [DataW-1:0] offCoef,
  input  logic [GainW-1:0] gainCoef,
  input  logic             outValid,
  output logic [DataW-1:0] outData,
  output logic             outOvf
);
  // stage 1 value carries one fraction bit (half LSB)
  localparam int D1W  = DataW + 2;
  localparam int PW   = D1W + GainW + 1;
  localparam int ExtW = PW - D1W;
  localparam int VW   = PW + 1;
  localparam int FracTot = GainFrac + 1;

  localparam logic signed [VW-1:0] Half   = VW'(1) <<< (FracTot - 1);
  localparam logic signed [VW-1:0] BipMax = (VW'(1) <<< (DataW - 1)) - VW'(1);
  localparam logic signed [VW-1:0] BipMin = -(VW'(1) <<< (DataW - 1));
  localparam logic signed [VW-1:0] UniMax = (VW'(1) <<< DataW) - VW'(1);

  logic signed [D1W-1:0] d1Q;
  logic [GainW-1:0]      gainQ;
  logic signed [PW-1:0]  pQ;

  logic signed [D1W-1:0] xExt, offExt, d1Next;
  logic signed [PW-1:0]  pNext;
  logic signed [VW-1:0]  vScaled, vRounded;
  logic [DataW-1:0]      satData;
  logic                  satOvf;

  // stage 1: offset subtraction at half-LSB resolution
  always_comb begin
    xExt   = {{2{inData[DataW-1]}}, inData} <<< 1;
    offExt = {{2{offCoef[DataW-1]}}, offCoef};
    d1Next = stb.subOff ? (xExt - offExt) : xExt;
  end

  // stage 2: fractional gain, or unity with matching alignment
  always_comb begin
    if (stb.mulGain) pNext = d1Q * $signed({1'b0, gainQ});
    else             pNext = {{ExtW{d1Q[D1W-1]}}, d1Q} <<< GainFrac;
  end

  // stage 3: polarity scale, round half up, clip
  always_comb begin
    vScaled  = stb.dblScale ? ({pQ, 1'b0}) : ({pQ[PW-1], pQ});
    vRounded = (vScaled + Half) >>> FracTot;
    satOvf   = 1'b0;
    satData  = vRounded[DataW-1:0];
    if (stb.dblScale) begin
      if (vRounded < 0) begin
        satData = '0;
        satOvf  = 1'b1;
      end else if (vRounded > UniMax) begin
        satData = '1;
        satOvf  = 1'b1;
      end
    end else begin
      if (vRounded < BipMin) begin
        satData = {1'b1, {(DataW-1){1'b0}}};
        satOvf  = 1'b1;
      end else if (vRounded > BipMax) begin
        satData = {1'b0, {(DataW-1){1'b1}}};
        satOvf  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      d1Q     <= '0;
      gainQ   <= '0;
      pQ      <= '0;
      outData <= '0;
      outOvf  <= 1'b0;
    end else begin
      if (stb.ld1) begin
        d1Q   <= d1Next;
        gainQ <= gainCoef;
      end
      if (stb.ld2) pQ <= pNext;
      if (stb.ld3) begin
        outData <= satData;
        outOvf  <= satOvf;
      end
    end
  end

  // R11: output holds when no sample is presented
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outOvf)));

  // R8: a bipolar clip lands on a signed rail
  assert_bip_rail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOvf && !stb.outUni) |->
      (outData == {1'b0, {(DataW-1){1'b1}}} || outData == {1'b1, {(DataW-1){1'b0}}}));

  // R9: a unipolar clip lands on zero or full scale
  assert_uni_rail_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOvf && stb.outUni) |->
      (outData == '0 || outData == '1));
endmodule

// File: rtl/sysCalPipe.sv
module sysCalPipe #(
  parameter int DataW = 24,
  parameter int GainW = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DataW-1:0] inData,
  input  logic [DataW-1:0] offCoef,
  input  logic [GainW-1:0] gainCoef,
  input  logic             offBypass,
  input  logic             gainBypass,
  input  logic             unipolar,
  output logic             outValid,
  output logic [DataW-1:0] outData,
  output logic             outOvf
);
  sysCalPkg::stageStb_t stb;

  sysCalCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .offBypass(offBypass), .gainBypass(gainBypass), .unipolar(unipolar),
    .stb(stb), .outValid(outValid)
  );

  sysCalData #(.DataW(DataW), .GainW(GainW), .GainFrac(GainW - 1)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inData(inData), .offCoef(offCoef), .gainCoef(gainCoef),
    .outValid(outValid), .outData(outData), .outOvf(outOvf)
  );
endmodule

// File: tb/sysCalPipe_tb.sv
`timescale 1ns/1ps
module sysCalPipe_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inData = '0, offCoef = '0, gainCoef = '0;
  logic        offBypass = 1'b0, gainBypass = 1'b0, unipolar = 1'b0;
  logic        outValid;
  logic [23:0] outData;
  logic        outOvf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sysCalPipe dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .offCoef(offCoef), .gainCoef(gainCoef), .offBypass(offBypass),
    .gainBypass(gainBypass), .unipolar(unipolar),
    .outValid(outValid), .outData(outData), .outOvf(outOvf)
  );

  typedef struct packed {
    logic [23:0] x;
    logic [23:0] off;
    logic [23:0] gain;
    logic        ob;
    logic        gb;
    logic        uni;
    logic [23:0] expD;
    logic        expO;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{24'h0003E8, 24'h000000, 24'h800000, 0, 0, 0, 24'h0003E8, 0, 8'd5},  // R5 unity
    '{24'h0003E8, 24'h0000C8, 24'h800000, 0, 0, 0, 24'h000384, 0, 8'd3},  // R3
    '{24'h0003E8, 24'h0000C8, 24'h800000, 1, 0, 0, 24'h0003E8, 0, 8'd4},  // R4
    '{24'h000064, 24'h000001, 24'h800000, 0, 0, 0, 24'h000064, 0, 8'd7},  // R7 99.5
    '{24'hFFFF9C, 24'h000001, 24'h800000, 0, 0, 0, 24'hFFFF9C, 0, 8'd7},  // R7 -100.5
    '{24'h000000, 24'hFFFFFD, 24'h800000, 0, 0, 0, 24'h000002, 0, 8'd7},  // R7 1.5
    '{24'h0003E8, 24'h000000, 24'hC00000, 0, 0, 0, 24'h0005DC, 0, 8'd5},  // R5 1.5x
    '{24'h0003E8, 24'h000000, 24'h600000, 0, 0, 0, 24'h0002EE, 0, 8'd5},  // R5 0.75x
    '{24'h0003E8, 24'h0000C8, 24'h600000, 0, 0, 0, 24'h0002A3, 0, 8'd5},  // R5 after R3
    '{24'h0003E8, 24'h0000C8, 24'h600000, 0, 1, 0, 24'h000384, 0, 8'd6},  // R6
    '{24'h0003E9, 24'h000000, 24'h600000, 0, 0, 0, 24'h0002EF, 0, 8'd7},  // R7 750.75
    '{24'h700000, 24'h000000, 24'hC00000, 0, 0, 0, 24'h7FFFFF, 1, 8'd8},  // R8 high clip
    '{24'h900000, 24'h000000, 24'hC00000, 0, 0, 0, 24'h800000, 1, 8'd8},  // R8 low clip
    '{24'h7FFFFF, 24'h000000, 24'h800000, 1, 1, 0, 24'h7FFFFF, 0, 8'd8},  // R8 edge
    '{24'h800000, 24'h000000, 24'h800000, 1, 1, 0, 24'h800000, 0, 8'd8},  // R8 edge
    '{24'h0003E8, 24'h000000, 24'h800000, 0, 0, 1, 24'h0007D0, 0, 8'd9},  // R9 2x
    '{24'hFFFFFB, 24'h000000, 24'h800000, 0, 0, 1, 24'h000000, 1, 8'd9},  // R9 low clip
    '{24'h600000, 24'h000000, 24'hC00000, 0, 0, 1, 24'hFFFFFF, 1, 8'd9},  // R9 high clip
    '{24'h000064, 24'h000001, 24'h800000, 0, 0, 1, 24'h0000C7, 0, 8'd9}   // R9 half LSB doubled
  };

  task automatic check(input bit ok, input string req, input logic [24:0] act,
                       input logic [24:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    inValid = 1'b1; inData = v.x; offCoef = v.off; gainCoef = v.gain;
    offBypass = v.ob; gainBypass = v.gb; unipolar = v.uni;
  endtask

  task automatic scramble();
    inValid = 1'b0; inData = 24'h5A5A5A; offCoef = 24'h123456;
    gainCoef = 24'hFFFFFF; offBypass = ~offBypass; gainBypass = ~gainBypass;
    unipolar = ~unipolar;
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected 20000", cycles);
      finish();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 0 && outData == 0 && outOvf == 0, "R1 in reset",
          {outValid, outData}, 25'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 0 && outData == 0 && outOvf == 0, "R1 after release",
          {outValid, outData}, 25'h0);

    // table walk; inputs are scrambled one cycle after acceptance (R10)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      scramble();
      @(negedge clk);
      @(negedge clk);
      check(outValid && outData == VECS[i].expD && outOvf == VECS[i].expO,
            $sformatf("R%0d vector %0d", VECS[i].req, i),
            {outOvf, outData}, {VECS[i].expO, VECS[i].expD});
      @(negedge clk);
    end

    // R2: exact latency and single-cycle valid; R11: hold when idle
    drive(VECS[1]);
    @(negedge clk); scramble();
    @(negedge clk);
    check(outValid == 0, "R2 early valid", {24'h0, outValid}, 25'h0);
    @(negedge clk);
    check(outValid == 1, "R2 valid at third edge", {24'h0, outValid}, 25'h1);
    @(negedge clk);
    check(outValid == 0, "R2 single-cycle valid", {24'h0, outValid}, 25'h0);
    check(outData == 24'h000384 && outOvf == 0, "R11 hold when idle",
          {outOvf, outData}, 25'h000384);
    repeat (3) @(negedge clk);
    check(outData == 24'h000384 && outOvf == 0, "R11 hold later",
          {outOvf, outData}, 25'h000384);

    // R10: back-to-back samples with differing settings
    drive(VECS[11]);  // bipolar high clip
    @(negedge clk); drive(VECS[15]);  // unipolar 2x
    @(negedge clk); drive(VECS[9]);   // gain bypass
    @(negedge clk); scramble();
    check(outValid && outData == 24'h7FFFFF && outOvf == 1, "R10 stream 0",
          {outOvf, outData}, 25'h17FFFF);
    @(negedge clk);
    check(outValid && outData == 24'h0007D0 && outOvf == 0, "R10 stream 1",
          {outOvf, outData}, 25'h0007D0);
    @(negedge clk);
    check(outValid && outData == 24'h000384 && outOvf == 0, "R10 stream 2",
          {outOvf, outData}, 25'h000384);
    @(negedge clk);
    check(outValid == 0, "R2 stream ends", {24'h0, outValid}, 25'h0);

    // R1: reset mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 0 && outData == 0 && outOvf == 0, "R1 re-reset",
          {outOvf, outData}, 25'h0);
    finish();
  end
endmodule